// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block keeps the status flags and the interrupt-pending flag of an I2C controller that can work as bus master or as addressed slave. The bit engine, glitch filter and timeout counters sit elsewhere. They report to this block through single-cycle event strobes: START seen, STOP seen, arbitration lost, eight data bits done, acknowledge slot done, SMBus timeout (with its kind), and calling address received (with its R/W bit and a hit flag from the fixed-address decoder).

The block also takes the configuration bits and a small register write port. Through that port, software clears flags by writing ones to them, and any write to the control register drops the range-match flag. The outputs are a status byte, a separate start/stop detect byte, and an interrupt request.

The interrupt-pending flag gathers several qualified sources. Where the byte-complete point falls depends on the acknowledge-timing setting. While a start/stop detect flag is still set, the pending flag cannot stay cleared: software has to clear the detect flags first.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset, both output bytes and `irq` are 0. The status byte layout is: bit 5 bus busy, bit 4 arbitration lost, bit 3 range match, bit 2 slave R/W, bit 1 interrupt pending. Bits 7, 6 and 0 always read 0.
- R2: Bus busy is 1 in the cycle after `ev_start` and 0 in the cycle after `ev_stop`. When both strobes arrive in the same cycle, busy becomes 1.
- R3: Arbitration lost sets one cycle after `ev_arb_lost`. It clears after a write with `wr_sel`=1 and `wr_data[4]`=1. A write with `wr_data[4]`=0 leaves it unchanged.
- R4: Range match sets one cycle after `ev_addr` only when `cfg_rmen`=1 and `cfg_iicie`=1, and only for a nonzero address that equals `cfg_hi_addr` or lies in [`cfg_lo_addr`, `cfg_hi_addr`] inclusive. Address 0 never sets it.
- R5: Any write with `wr_sel`=0 clears range match, whatever the data value.
- R6: On an address event that hits (`addr_ext_hit`=1 or a range hit), slave R/W takes `addr_rw` one cycle later. Otherwise it holds.
- R7: With `cfg_fack`=0, interrupt pending sets after `ev_ack_done`, and `ev_byte8` alone does not set it. With `cfg_fack`=1, it is the other way round.
- R8: Interrupt pending also sets on an address hit, on arbitration lost, and on `ev_tmo` when `tmo_kind` is 0 (SCL low) or 3 (other). Kinds 1 (SCL high) and 2 (SDA high) do not set it.
- R9: With `cfg_ssie`=1, a START sets `det_flags[0]`, a STOP sets `det_flags[1]`, and either one sets interrupt pending. With `cfg_ssie`=0, neither sets anything. A write with `wr_sel`=2 clears the flags at the positions where `wr_data` has a 1.
- R10: Interrupt pending clears after a write with `wr_sel`=1 and `wr_data[1]`=1. If a detect flag is set at that point, pending reads 0 for one cycle and then 1 again.
- R11: When a hardware set and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R12: `irq` is 1 exactly when interrupt pending is 1 and `cfg_iicie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | START condition seen (strobe) |
| ev_stop | input | 1 | STOP condition seen (strobe) |
| ev_arb_lost | input | 1 | Arbitration lost (strobe) |
| ev_byte8 | input | 1 | Eight data bits transferred (strobe) |
| ev_ack_done | input | 1 | Acknowledge slot finished (strobe) |
| ev_tmo | input | 1 | SMBus timeout (strobe) |
| tmo_kind | input | 2 | Timeout kind: 0 SCL low, 1 SCL high, 2 SDA high, 3 other |
| ev_addr | input | 1 | Calling address received (strobe) |
| addr_rx | input | 7 | Received calling address |
| addr_rw | input | 1 | R/W bit of the calling address |
| addr_ext_hit | input | 1 | Fixed-address decoder matched (primary, second, alert, general call) |
| cfg_fack | input | 1 | Byte-done point before the acknowledge slot |
| cfg_ssie | input | 1 | Start/stop detection enable |
| cfg_rmen | input | 1 | Range matching enable |
| cfg_iicie | input | 1 | Interrupt enable |
| cfg_lo_addr | input | 7 | Lower bound of the address range |
| cfg_hi_addr | input | 7 | Upper bound of the address range |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 detect byte |
| wr_data | input | 8 | Write data |
| status | output | 8 | Status byte |
| det_flags | output | 8 | Start/stop detect byte |
| irq | output | 1 | Interrupt request |

## Verification
Every flag is a single register fed straight from the strobes and the write port, so each flag changes one clock after the cycle that carries its cause. `irq` follows interrupt pending and `cfg_iicie` in the same cycle. The one two-step result is the re-raise of a pending flag cleared too early: it reads 0 one cycle after the clear and 1 the cycle after that. The bench drives each stimulus on a falling edge, advances its model by one step, and compares every field at the next falling edge. It reads the re-raise as two separate samples.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int ST_BUSY = 5;
  localparam int ST_ARBL = 4;
  localparam int ST_RAM  = 3;
  localparam int ST_SRW  = 2;
  localparam int ST_IF   = 1;
  localparam int DF_START = 0;
  localparam int DF_STOP  = 1;

  typedef enum logic [1:0] {
    WSEL_CTRL = 2'd0,
    WSEL_STAT = 2'd1,
    WSEL_DET  = 2'd2,
    WSEL_NONE = 2'd3
  } wsel_e;

  localparam logic [1:0] TMO_SCL_HIGH = 2'd1;
  localparam logic [1:0] TMO_SDA_HIGH = 2'd2;

  // timeouts on a line stuck high do not raise the pending flag
  function automatic logic tmo_counts(input logic [1:0] kind);
    return !(kind == TMO_SCL_HIGH || kind == TMO_SDA_HIGH);
  endfunction

  // byte-complete point moves with the acknowledge-timing setting
  function automatic logic byte_point(input logic fack, input logic b8, input logic ack);
    return fack ? b8 : ack;
  endfunction

  // write-one-to-clear test on one bit position of the write byte
  function automatic logic w1c_bit(input logic [7:0] data, input int pos);
    return |(data & (8'd1 << pos));
  endfunction
endpackage

// File: rtl/i2c_bus_track.sv
module i2c_bus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ssie,
  input  logic clr_start,
  input  logic clr_stop,
  output logic busy,
  output logic startf,
  output logic stopf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      startf <= 1'b0;
      stopf  <= 1'b0;
    end else begin
      busy   <= ev_start | (busy & ~ev_stop);
      startf <= (ssie & ev_start) | (startf & ~clr_start);
      stopf  <= (ssie & ev_stop)  | (stopf  & ~clr_stop);
    end
  end
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_addr,
  input  logic [AW-1:0] addr_rx,
  input  logic          addr_rw,
  input  logic          ext_hit,
  input  logic          rmen,
  input  logic          iicie,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          ctrl_wr,
  output logic          rng_hit,
  output logic          any_hit,
  output logic          ram,
  output logic          srw
);
  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] l,
                                     input logic [AW-1:0] h);
    return (a != '0) && ((a == h) || ((a >= l) && (a <= h)));
  endfunction

  assign rng_hit = ev_addr & rmen & in_window(addr_rx, lo, hi);
  assign any_hit = (ev_addr & ext_hit) | rng_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram <= 1'b0;
      srw <= 1'b0;
    end else begin
      ram <= (rng_hit & iicie) | (ram & ~ctrl_wr);
      if (any_hit) srw <= addr_rw;
    end
  end
endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_pt,
  input  logic arb,
  input  logic addr_hit,
  input  logic tmo_hit,
  input  logic det_ev,
  input  logic det_pend,
  input  logic clr_arbl,
  input  logic clr_if,
  output logic arbl,
  output logic iicif,
  output logic iicif_set
);
  logic relatch;

  assign iicif_set = byte_pt | arb | addr_hit | tmo_hit | det_ev;
  assign relatch   = det_pend & ~iicif;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arbl  <= 1'b0;
      iicif <= 1'b0;
    end else begin
      arbl  <= arb | (arbl & ~clr_arbl);
      iicif <= iicif_set | relatch | (iicif & ~clr_if);
    end
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_arb_lost,
  input  logic          ev_byte8,
  input  logic          ev_ack_done,
  input  logic          ev_tmo,
  input  logic [1:0]    tmo_kind,
  input  logic          ev_addr,
  input  logic [AW-1:0] addr_rx,
  input  logic          addr_rw,
  input  logic          addr_ext_hit,
  input  logic          cfg_fack,
  input  logic          cfg_ssie,
  input  logic          cfg_rmen,
  input  logic          cfg_iicie,
  input  logic [AW-1:0] cfg_lo_addr,
  input  logic [AW-1:0] cfg_hi_addr,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic [7:0]    status,
  output logic [7:0]    det_flags,
  output logic          irq
);
  import i2c_stat_pkg::*;

  logic wr_ctrl, wr_stat, wr_det;
  logic busy, startf, stopf;
  logic rng_hit, any_hit, ram, srw;
  logic arbl, iicif, iicif_set;
  logic byte_pt, tmo_hit, det_ev;

  assign wr_ctrl = wr_en && (wr_sel == WSEL_CTRL);
  assign wr_stat = wr_en && (wr_sel == WSEL_STAT);
  assign wr_det  = wr_en && (wr_sel == WSEL_DET);

  assign byte_pt = byte_point(cfg_fack, ev_byte8, ev_ack_done);
  assign tmo_hit = ev_tmo & tmo_counts(tmo_kind);
  assign det_ev  = cfg_ssie & (ev_start | ev_stop);

  i2c_bus_track u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ssie      (cfg_ssie),
    .clr_start (wr_det & w1c_bit(wr_data, DF_START)),
    .clr_stop  (wr_det & w1c_bit(wr_data, DF_STOP)),
    .busy      (busy),
    .startf    (startf),
    .stopf     (stopf)
  );

  i2c_addr_cmp #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_addr (ev_addr),
    .addr_rx (addr_rx),
    .addr_rw (addr_rw),
    .ext_hit (addr_ext_hit),
    .rmen    (cfg_rmen),
    .iicie   (cfg_iicie),
    .lo      (cfg_lo_addr),
    .hi      (cfg_hi_addr),
    .ctrl_wr (wr_ctrl),
    .rng_hit (rng_hit),
    .any_hit (any_hit),
    .ram     (ram),
    .srw     (srw)
  );

  i2c_irq_flag u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_pt   (byte_pt),
    .arb       (ev_arb_lost),
    .addr_hit  (any_hit),
    .tmo_hit   (tmo_hit),
    .det_ev    (det_ev),
    .det_pend  (startf | stopf),
    .clr_arbl  (wr_stat & w1c_bit(wr_data, ST_ARBL)),
    .clr_if    (wr_stat & w1c_bit(wr_data, ST_IF)),
    .arbl      (arbl),
    .iicif     (iicif),
    .iicif_set (iicif_set)
  );

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = busy;
    status[ST_ARBL]  = arbl;
    status[ST_RAM]   = ram;
    status[ST_SRW]   = srw;
    status[ST_IF]    = iicif;
    det_flags           = '0;
    det_flags[DF_START] = startf;
    det_flags[DF_STOP]  = stopf;
  end

  assign irq = iicif & cfg_iicie;
endmodule

// File: rtl/i2c_stat_irq_chk.sv
module i2c_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_arb_lost,
  input logic       cfg_iicie,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       arbl,
  input logic       ram,
  input logic       iicif,
  input logic       startf,
  input logic       stopf,
  input logic       rng_hit,
  input logic       iicif_set,
  input logic       irq
);
  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy);
  // R2
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_start) |=> !busy);
  // R3
  arbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> arbl);
  // R3
  arbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arbl && !(wr_en && wr_sel == 2'd1 && wr_data[4])) |=> arbl);
  // R4
  ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram) |-> $past(cfg_iicie));
  // R5
  ram_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !rng_hit) |=> !ram);
  // R10
  relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iicif && (startf || stopf)) |=> iicif);
  // R11
  if_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iicif_set |=> iicif);
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_iicie |-> !irq);
endmodule

bind i2c_stat_irq i2c_stat_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .ev_arb_lost (ev_arb_lost),
  .cfg_iicie   (cfg_iicie),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .busy        (busy),
  .arbl        (arbl),
  .ram         (ram),
  .iicif       (iicif),
  .startf      (startf),
  .stopf       (stopf),
  .rng_hit     (rng_hit),
  .iicif_set   (iicif_set),
  .irq         (irq)
);

// File: tb/test_i2c_stat_irq.sv
module test_i2c_stat_irq;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_start, ev_stop, ev_arb_lost, ev_byte8, ev_ack_done, ev_tmo;
  logic [1:0] tmo_kind;
  logic ev_addr, addr_rw, addr_ext_hit;
  logic [6:0] addr_rx;
  logic cfg_fack, cfg_ssie, cfg_rmen, cfg_iicie;
  logic [6:0] cfg_lo_addr, cfg_hi_addr;
  logic wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  wire  [7:0] status, det_flags;
  wire        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit m_busy, m_arbl, m_ram, m_srw, m_if, m_stf, m_spf;

  always #4 clk = ~clk;

  i2c_stat_irq i_i2c_stat_irq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_arb_lost(ev_arb_lost), .ev_byte8(ev_byte8), .ev_ack_done(ev_ack_done),
    .ev_tmo(ev_tmo), .tmo_kind(tmo_kind), .ev_addr(ev_addr), .addr_rx(addr_rx),
    .addr_rw(addr_rw), .addr_ext_hit(addr_ext_hit), .cfg_fack(cfg_fack),
    .cfg_ssie(cfg_ssie), .cfg_rmen(cfg_rmen), .cfg_iicie(cfg_iicie),
    .cfg_lo_addr(cfg_lo_addr), .cfg_hi_addr(cfg_hi_addr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .status(status), .det_flags(det_flags),
    .irq(irq)
  );

  function automatic bit b_win(int a, int lo, int hi);
    if (a == 0) return 0;
    if (a == hi) return 1;
    return (lo <= a) && (a <= hi);
  endfunction

  function automatic bit b_tmo(int k);
    return (k == 0) || (k == 3);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_start = 0; ev_stop = 0; ev_arb_lost = 0; ev_byte8 = 0; ev_ack_done = 0;
    ev_tmo = 0; tmo_kind = 0; ev_addr = 0; addr_rx = 0; addr_rw = 0;
    addr_ext_hit = 0; wr_en = 0; wr_sel = 2'd3; wr_data = 0;
  endtask

  task automatic model_next();
    bit wc, ws, wd, rh, am, bp, setif;
    bit n_busy, n_arbl, n_ram, n_srw, n_if, n_stf, n_spf;
    wc = wr_en && wr_sel == 2'd0;
    ws = wr_en && wr_sel == 2'd1;
    wd = wr_en && wr_sel == 2'd2;
    rh = ev_addr && cfg_rmen && b_win(addr_rx, cfg_lo_addr, cfg_hi_addr);
    am = (ev_addr && addr_ext_hit) || rh;
    bp = cfg_fack ? ev_byte8 : ev_ack_done;
    setif = bp || ev_arb_lost || am || (ev_tmo && b_tmo(tmo_kind)) ||
            (cfg_ssie && (ev_start || ev_stop));
    n_busy = ev_start ? 1'b1 : (ev_stop ? 1'b0 : m_busy);
    n_arbl = ev_arb_lost || (m_arbl && !(ws && wr_data[4]));
    n_ram  = (rh && cfg_iicie) || (m_ram && !wc);
    n_srw  = am ? addr_rw : m_srw;
    n_if   = setif || (!m_if && (m_stf || m_spf)) || (m_if && !(ws && wr_data[1]));
    n_stf  = (cfg_ssie && ev_start) || (m_stf && !(wd && wr_data[0]));
    n_spf  = (cfg_ssie && ev_stop)  || (m_spf && !(wd && wr_data[1]));
    m_busy = n_busy; m_arbl = n_arbl; m_ram = n_ram; m_srw = n_srw;
    m_if = n_if; m_stf = n_stf; m_spf = n_spf;
  endtask

  task automatic compare_all();
    check("R2 busy", status[5], m_busy);
    check("R3 arbitration lost", status[4], m_arbl);
    check("R4 range match", status[3], m_ram);
    check("R6 slave rw", status[2], m_srw);
    check("R7 pending", status[1], m_if);
    check("R1 unused status bits", {status[7:6], status[0]}, 0);
    check("R9 detect byte", det_flags, {6'd0, m_spf, m_stf});
    check("R12 irq", irq, m_if & cfg_iicie);
  endtask

  task automatic step();
    model_next();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(data);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250607));
    idle();
    cfg_fack = 0; cfg_ssie = 0; cfg_rmen = 0; cfg_iicie = 0;
    cfg_lo_addr = 0; cfg_hi_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status, 0);
    check("R1 reset detect", det_flags, 0);
    check("R1 reset irq", irq, 0);

    // R2 busy set, clear, both
    ev_start = 1; step(); check("R2 busy after start", status[5], 1);
    ev_stop = 1;  step(); check("R2 busy after stop", status[5], 0);
    ev_start = 1; ev_stop = 1; step(); check("R2 start wins", status[5], 1);

    // R3 / R11 arbitration lost
    ev_arb_lost = 1; wr(1, 8'h10); step(); check("R11 arbl set over clear", status[4], 1);
    wr(1, 8'hEF); step(); check("R3 write 0 keeps arbl", status[4], 1);
    wr(1, 8'h10); step(); check("R3 write 1 clears arbl", status[4], 0);
    wr(1, 8'h02); step(); check("R10 pending cleared", status[1], 0);

    // R4 / R5 / R6 range match
    cfg_rmen = 1; cfg_iicie = 1; cfg_lo_addr = 7'h10; cfg_hi_addr = 7'h20;
    ev_addr = 1; addr_rx = 7'h15; addr_rw = 1; step();
    check("R4 range inside", status[3], 1);
    check("R6 rw captured", status[2], 1);
    check("R12 irq with enable", irq, 1);
    wr(0, 8'h00); step(); check("R5 control write clears", status[3], 0);
    cfg_lo_addr = 7'h00; ev_addr = 1; addr_rx = 7'h00; step();
    check("R4 zero address ignored", status[3], 0);
    cfg_lo_addr = 7'h30; ev_addr = 1; addr_rx = 7'h20; addr_rw = 0; step();
    check("R4 equal upper bound", status[3], 1);
    check("R6 rw zero", status[2], 0);
    wr(0, 8'hFF); step();
    ev_addr = 1; addr_rx = 7'h25; step(); check("R4 outside range", status[3], 0);
    cfg_iicie = 0; ev_addr = 1; addr_rx = 7'h20; step();
    check("R4 needs interrupt enable", status[3], 0);
    check("R12 irq masked", irq, 0);
    cfg_iicie = 1;
    wr(1, 8'h02); step();

    // R7 byte point
    cfg_fack = 1; ev_ack_done = 1; step(); check("R7 fack=1 ack ignored", status[1], 0);
    ev_byte8 = 1; step(); check("R7 fack=1 byte8 sets", status[1], 1);
    wr(1, 8'h02); step();
    cfg_fack = 0; ev_byte8 = 1; step(); check("R7 fack=0 byte8 ignored", status[1], 0);
    ev_ack_done = 1; step(); check("R7 fack=0 ack sets", status[1], 1);
    wr(1, 8'h02); step();

    // R8 timeouts
    for (int k = 0; k < 4; k++) begin
      ev_tmo = 1; tmo_kind = 2'(k); step();
      check("R8 timeout kind", status[1], (k == 0 || k == 3) ? 1 : 0);
      wr(1, 8'h02); step();
    end

    // R9 / R10 detect flags and re-raise
    ev_start = 1; step(); check("R9 ssie=0 no detect", det_flags, 0);
    cfg_ssie = 1; ev_stop = 1; step();
    check("R9 stop flag", det_flags, 8'h02);
    check("R9 pending from stop", status[1], 1);
    wr(1, 8'h02); step(); check("R10 cleared one cycle", status[1], 0);
    step(); check("R10 re-raised", status[1], 1);
    ev_start = 1; wr(2, 8'h01); step(); check("R11 start flag set wins", det_flags, 8'h03);
    wr(2, 8'h03); step(); check("R9 flags cleared", det_flags, 0);
    wr(1, 8'h02); step(); step(); check("R10 stays clear", status[1], 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      if ($urandom_range(0, 31) == 0) begin
        cfg_fack = 1'($urandom); cfg_ssie = 1'($urandom);
        cfg_rmen = 1'($urandom); cfg_iicie = 1'($urandom);
        cfg_lo_addr = 7'($urandom); cfg_hi_addr = 7'($urandom);
      end
      ev_start    = ($urandom_range(0, 9) == 0);
      ev_stop     = ($urandom_range(0, 9) == 0);
      ev_arb_lost = ($urandom_range(0, 15) == 0);
      ev_byte8    = ($urandom_range(0, 7) == 0);
      ev_ack_done = ($urandom_range(0, 7) == 0);
      ev_tmo      = ($urandom_range(0, 15) == 0);
      tmo_kind    = 2'($urandom);
      ev_addr     = ($urandom_range(0, 5) == 0);
      addr_rw     = 1'($urandom);
      addr_ext_hit = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 5);
      case (r)
        0: addr_rx = cfg_lo_addr;
        1: addr_rx = cfg_hi_addr;
        2: addr_rx = cfg_lo_addr - 7'd1;
        3: addr_rx = cfg_hi_addr + 7'd1;
        4: addr_rx = 7'd0;
        default: addr_rx = 7'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 3), $urandom_range(0, 255));
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule